// File: doc/BRIEF.md
# Bit-Serial Receive Frame Buffer

This block holds demodulated payload bits one at a time between a receiver front end and a host that pulls them out over a serial readout. The front end presents a data bit together with a data-clock strobe. Nothing is stored until a frame-sync event arms the write side. Storing then continues, one bit per strobe, until end-of-message or loss of sync halts it. The halted buffer shows a lock status that marks a completed frame.

The host reads the oldest unread bit on a combinational output. It advances by one position for every serial bit it shifts out. It may start reading as soon as sync arrives, so a frame longer than the buffer can be drained while it is still arriving. A level output gives the number of unread bits. A sticky overflow flag records any bit lost because the buffer was full.

When the extended sync mode is selected, the arming event also stores one leading bit that identifies which of two sync patterns matched. An initialise command empties the buffer, clears its contents and flags, and waits for the next sync.

Top module: `rxf_bit_fifo`

## Requirements
- R1: The buffer holds up to DEPTH bits (default 256). `level_o` reports the number of unread bits, from 0 to DEPTH, and never exceeds DEPTH.
- R2: While no frame has been armed since reset or initialise, data strobes store nothing and `level_o` stays 0.
- R3: After `sync_hit_i` arms the buffer, each `rx_strobe_i` cycle stores `rx_bit_i` at the write position and advances that position by one. The strobe in the arming cycle itself is not stored.
- R4: `rd_bit_o` shows the oldest unread bit. Each `rd_shift_i` cycle with `level_o` above 0 advances the read position by one. Both positions wrap from DEPTH-1 to 0, so bits come out in arrival order across the wrap.
- R5: End-of-message or sync loss during an armed frame stops writing and raises `lock_o`. A strobe in that same cycle is discarded. Later strobes and sync events have no effect until initialise.
- R6: With `ext_mode_i` high, the arming cycle stores `pat_sel_i` as the first bit, ahead of the payload.
- R7: When `level_o` is 0, `rd_bit_o` is 0 and `rd_shift_i` does not move the read position. A later write is then the next bit read.
- R8: A write attempted while `level_o` equals DEPTH at the start of the cycle is discarded, even if a read happens in the same cycle. Such a write sets `ovf_o`, which stays set until initialise.
- R9: `init_i` takes priority over every other input in its cycle. From the next cycle, `level_o`, `ovf_o` and `lock_o` are 0, both positions are 0, the contents are cleared, and the block waits for a new sync.
- R10: A cycle with both an accepted write and an accepted read leaves `level_o` unchanged, so the host can drain the buffer while a frame is still arriving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialise command |
| sync_hit_i | input | 1 | Frame-sync detected, arms writing |
| eom_i | input | 1 | End of message, stops writing |
| sync_lost_i | input | 1 | Sync lost, stops writing |
| rx_strobe_i | input | 1 | Data-clock strobe from the receiver |
| rx_bit_i | input | 1 | Received data bit |
| ext_mode_i | input | 1 | Extended sync mode: store the pattern selector first |
| pat_sel_i | input | 1 | Which of the two sync patterns matched |
| rd_shift_i | input | 1 | One serial bit shifted out to the host |
| rd_bit_o | output | 1 | Oldest unread bit, 0 when empty |
| level_o | output | $clog2(DEPTH+1) | Number of unread bits |
| ovf_o | output | 1 | Sticky overflow flag |
| lock_o | output | 1 | Frame completed, writing halted |

## Verification
The bench builds the block with DEPTH set to 16. With that depth, filling to full, attempting a write past full, and wrapping both positions from 15 back to 0 each take only a few dozen cycles. Because of this, the overflow path and the wrap path can be run together with reads in the same cycle as writes. A reference queue in the bench tracks the expected unread bits. The bench checks it against the level and read outputs after the arming, stopping, extended-mode and initialise cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_RUN  = 2'd1,
        WR_DONE = 2'd2
    } wr_state_e;

endpackage

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl #(
    parameter  int DEPTH = 256,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          sync_hit_i,
    input  logic          eom_i,
    input  logic          sync_lost_i,
    input  logic          strobe_i,
    input  logic          bit_i,
    input  logic          ext_mode_i,
    input  logic          pat_sel_i,
    input  logic          full_i,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_addr_o,
    output logic          wr_data_o,
    output logic          ovf_o,
    output logic          lock_o
);
    import rxf_pkg::*;

    typedef struct packed {
        wr_state_e     st;
        logic [PW-1:0] wptr;
        logic          ovf;
    } wr_regs_t;

    wr_regs_t r_q, r_d;
    logic     want;
    logic     din;

    always_comb begin
        r_d       = r_q;
        want      = 1'b0;
        din       = 1'b0;
        wr_en_o   = 1'b0;
        wr_data_o = 1'b0;
        if (init_i) begin
            r_d.st   = WR_IDLE;
            r_d.wptr = '0;
            r_d.ovf  = 1'b0;
        end else begin
            unique case (r_q.st)
                WR_IDLE: begin
                    if (sync_hit_i) begin
                        r_d.st = WR_RUN;
                        if (ext_mode_i) begin
                            want = 1'b1;
                            din  = pat_sel_i;
                        end
                    end
                end
                WR_RUN: begin
                    if (eom_i || sync_lost_i) begin
                        r_d.st = WR_DONE;
                    end else if (strobe_i) begin
                        want = 1'b1;
                        din  = bit_i;
                    end
                end
                default: begin
                end
            endcase
            if (want) begin
                if (full_i) begin
                    r_d.ovf = 1'b1;
                end else begin
                    wr_en_o   = 1'b1;
                    wr_data_o = din;
                    r_d.wptr  = (r_q.wptr == PW'(DEPTH - 1)) ? '0 : r_q.wptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= WR_IDLE;
            r_q.wptr <= '0;
            r_q.ovf  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_addr_o = r_q.wptr;
    assign ovf_o     = r_q.ovf;
    assign lock_o    = (r_q.st == WR_DONE);

endmodule

// File: rtl/rxf_rd_ctrl.sv
module rxf_rd_ctrl #(
    parameter  int DEPTH = 256,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          shift_i,
    input  logic          wr_en_i,
    output logic [PW-1:0] rd_addr_o,
    output logic [CW-1:0] level_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          rd_fire_o
);
    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } rd_regs_t;

    rd_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        rd_fire_o = 1'b0;
        if (init_i) begin
            r_d.rptr = '0;
            r_d.cnt  = '0;
        end else begin
            rd_fire_o = shift_i && (r_q.cnt != '0);
            if (rd_fire_o) begin
                r_d.rptr = (r_q.rptr == PW'(DEPTH - 1)) ? '0 : r_q.rptr + 1'b1;
            end
            unique case ({wr_en_i, rd_fire_o})
                2'b10:   r_d.cnt = r_q.cnt + 1'b1;
                2'b01:   r_d.cnt = r_q.cnt - 1'b1;
                default: r_d.cnt = r_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.rptr <= '0;
            r_q.cnt  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr_o = r_q.rptr;
    assign level_o   = r_q.cnt;
    assign empty_o   = (r_q.cnt == '0);
    assign full_o    = (r_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/rxf_bit_array.sv
module rxf_bit_array #(
    parameter  int DEPTH = 256,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_addr_i,
    input  logic          wr_data_i,
    input  logic [PW-1:0] rd_addr_i,
    output logic          rd_data_o
);
    logic [DEPTH-1:0] cell_q, cell_d;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        always_comb begin
            if (init_i) begin
                cell_d[gi] = 1'b0;
            end else if (wr_en_i && (wr_addr_i == PW'(gi))) begin
                cell_d[gi] = wr_data_i;
            end else begin
                cell_d[gi] = cell_q[gi];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];

endmodule

// File: rtl/rxf_bit_fifo.sv
module rxf_bit_fifo #(
    parameter  int DEPTH = 256,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          sync_hit_i,
    input  logic          eom_i,
    input  logic          sync_lost_i,
    input  logic          rx_strobe_i,
    input  logic          rx_bit_i,
    input  logic          ext_mode_i,
    input  logic          pat_sel_i,
    input  logic          rd_shift_i,
    output logic          rd_bit_o,
    output logic [CW-1:0] level_o,
    output logic          ovf_o,
    output logic          lock_o
);
    logic          wr_en;
    logic [PW-1:0] wr_addr;
    logic          wr_data;
    logic [PW-1:0] rd_addr;
    logic          rd_data;
    logic          empty;
    logic          full;
    logic          rd_fire;

    rxf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .sync_hit_i  (sync_hit_i),
        .eom_i       (eom_i),
        .sync_lost_i (sync_lost_i),
        .strobe_i    (rx_strobe_i),
        .bit_i       (rx_bit_i),
        .ext_mode_i  (ext_mode_i),
        .pat_sel_i   (pat_sel_i),
        .full_i      (full),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .ovf_o       (ovf_o),
        .lock_o      (lock_o)
    );

    rxf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .shift_i   (rd_shift_i),
        .wr_en_i   (wr_en),
        .rd_addr_o (rd_addr),
        .level_o   (level_o),
        .empty_o   (empty),
        .full_o    (full),
        .rd_fire_o (rd_fire)
    );

    rxf_bit_array #(.DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    assign rd_bit_o = rd_data & ~empty;

endmodule

// File: rtl/rxf_bit_fifo_chk.sv
module rxf_bit_fifo_chk #(
    parameter  int DEPTH = 256,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          init_i,
    input logic          rd_bit_o,
    input logic [CW-1:0] level_o,
    input logic          ovf_o,
    input logic          lock_o,
    input logic          wr_en,
    input logic          rd_fire
);
    // R1
    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= CW'(DEPTH));

    // R7
    a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> !rd_bit_o);

    // R8
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !init_i) |=> ovf_o);

    // R8
    a_r8_full_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == CW'(DEPTH)) |-> !wr_en);

    // R5
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !init_i) |=> lock_o);

    // R5
    a_r5_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !wr_en);

    // R9
    a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (level_o == '0) && !ovf_o && !lock_o);

    // R10
    a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && wr_en && rd_fire) |=> $stable(level_o));

endmodule

bind rxf_bit_fifo rxf_bit_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_i),
    .rd_bit_o (rd_bit_o),
    .level_o  (level_o),
    .ovf_o    (ovf_o),
    .lock_o   (lock_o),
    .wr_en    (wr_en),
    .rd_fire  (rd_fire)
);

// File: tb/rxf_bit_fifo_tb.sv
`timescale 1ns/1ps
module rxf_bit_fifo_tb;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 0, sync_hit_i = 0, eom_i = 0, sync_lost_i = 0;
    logic rx_strobe_i = 0, rx_bit_i = 0, ext_mode_i = 0, pat_sel_i = 0, rd_shift_i = 0;
    logic          rd_bit_o;
    logic [CW-1:0] level_o;
    logic          ovf_o;
    logic          lock_o;

    int checks = 0;
    int errors = 0;

    // reference model
    bit mq[$];
    int mst = 0;
    bit movf = 0;

    always #4 clk = ~clk;

    rxf_bit_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .sync_hit_i(sync_hit_i),
        .eom_i(eom_i), .sync_lost_i(sync_lost_i), .rx_strobe_i(rx_strobe_i),
        .rx_bit_i(rx_bit_i), .ext_mode_i(ext_mode_i), .pat_sel_i(pat_sel_i),
        .rd_shift_i(rd_shift_i), .rd_bit_o(rd_bit_o), .level_o(level_o),
        .ovf_o(ovf_o), .lock_o(lock_o)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        chk(int'(level_o), mq.size(), req, "level");
        chk(int'(rd_bit_o), (mq.size() > 0) ? int'(mq[0]) : 0, req, "rd_bit");
        chk(int'(ovf_o), int'(movf), req, "ovf");
        chk(int'(lock_o), (mst == 2) ? 1 : 0, req, "lock");
    endtask

    task automatic tick();
        bit want;
        bit din;
        int pre;
        want = 0;
        din  = 0;
        pre  = mq.size();
        if (init_i) begin
            mq.delete();
            mst  = 0;
            movf = 0;
        end else begin
            case (mst)
                0: if (sync_hit_i) begin
                       mst = 1;
                       if (ext_mode_i) begin want = 1; din = pat_sel_i; end
                   end
                1: if (eom_i || sync_lost_i) mst = 2;
                   else if (rx_strobe_i) begin want = 1; din = rx_bit_i; end
                default: ;
            endcase
            if (rd_shift_i && pre > 0) void'(mq.pop_front());
            if (want) begin
                if (pre == DEPTH) movf = 1;
                else mq.push_back(din);
            end
        end
        @(negedge clk);
        init_i = 0; sync_hit_i = 0; eom_i = 0; sync_lost_i = 0;
        rx_strobe_i = 0; rx_bit_i = 0; rd_shift_i = 0;
    endtask

    task automatic wr(input bit b);
        rx_strobe_i = 1; rx_bit_i = b; tick();
    endtask

    task automatic rd();
        rd_shift_i = 1; tick();
    endtask

    task automatic do_init();
        init_i = 1; tick();
    endtask

    task automatic t_reset();
        chk(int'(level_o), 0, "R1", "reset level");
        chk(int'(ovf_o), 0, "R9", "reset ovf");
        chk(int'(lock_o), 0, "R9", "reset lock");
        chk(int'(rd_bit_o), 0, "R7", "reset rd_bit");
    endtask

    task automatic t_presync();
        for (int i = 0; i < 4; i++) wr(1'b1);
        chk(int'(level_o), 0, "R2", "level before sync");
        rd();
        chk(int'(rd_bit_o), 0, "R7", "empty read");
    endtask

    task automatic t_basic();
        bit pat [10] = '{1,0,1,1,0,0,1,0,1,1};
        sync_hit_i = 1; rx_strobe_i = 1; rx_bit_i = 1; tick();
        chk(int'(level_o), 0, "R3", "arming strobe not stored");
        foreach (pat[i]) wr(pat[i]);
        chk(int'(level_o), 10, "R3", "level after 10 writes");
        foreach (pat[i]) begin
            chk(int'(rd_bit_o), int'(pat[i]), "R4", "read order");
            rd();
        end
        chk(int'(level_o), 0, "R4", "drained");
        rd();
        chk(int'(level_o), 0, "R7", "empty shift keeps level");
        wr(1'b1);
        chk(int'(rd_bit_o), 1, "R7", "next write read after empty shift");
        chk_model("R7");
    endtask

    task automatic t_stop(input bit use_lost);
        do_init();
        chk_model("R9");
        sync_hit_i = 1; tick();
        wr(1); wr(0); wr(1);
        if (use_lost) sync_lost_i = 1; else eom_i = 1;
        rx_strobe_i = 1; rx_bit_i = 1; tick();
        chk(int'(level_o), 3, "R5", "stop-cycle strobe discarded");
        chk(int'(lock_o), 1, "R5", "lock raised");
        wr(1); wr(1);
        sync_hit_i = 1; ext_mode_i = 1; pat_sel_i = 1; tick();
        ext_mode_i = 0; pat_sel_i = 0;
        chk(int'(level_o), 3, "R5", "ignored after stop");
        chk_model("R5");
        init_i = 1; rx_strobe_i = 1; rd_shift_i = 1; sync_hit_i = 1; tick();
        chk(int'(level_o), 0, "R9", "init level");
        chk(int'(lock_o), 0, "R9", "init lock");
        wr(1);
        chk(int'(level_o), 0, "R9", "waits for new sync");
        chk_model("R9");
    endtask

    task automatic t_ext();
        do_init();
        ext_mode_i = 1; pat_sel_i = 1; sync_hit_i = 1; tick();
        ext_mode_i = 0; pat_sel_i = 0;
        chk(int'(level_o), 1, "R6", "selector stored");
        chk(int'(rd_bit_o), 1, "R6", "selector first");
        wr(0); wr(0);
        rd();
        chk(int'(rd_bit_o), 0, "R6", "payload after selector");
        chk_model("R6");
    endtask

    task automatic t_wrap_ovf();
        do_init();
        sync_hit_i = 1; tick();
        for (int i = 0; i < DEPTH; i++) wr(i[0] ^ i[2]);
        chk(int'(level_o), DEPTH, "R1", "full level");
        wr(1'b1);
        chk(int'(ovf_o), 1, "R8", "overflow set");
        chk(int'(level_o), DEPTH, "R8", "level capped");
        for (int i = 0; i < 5; i++) rd();
        for (int i = 0; i < 5; i++) wr(i[0]);
        chk_model("R4");
        rx_strobe_i = 1; rx_bit_i = 1; rd_shift_i = 1; tick();
        chk(int'(level_o), DEPTH - 1, "R8", "full write with read discarded");
        chk(int'(ovf_o), 1, "R8", "ovf sticky");
        rx_strobe_i = 1; rx_bit_i = 0; rd_shift_i = 1; tick();
        chk(int'(level_o), DEPTH - 1, "R10", "simultaneous read/write");
        while (mq.size() > 0) begin
            chk(int'(rd_bit_o), int'(mq[0]), "R4", "order across wrap");
            rd();
        end
        chk_model("R4");
        do_init();
        chk(int'(ovf_o), 0, "R8", "ovf cleared by init");
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_presync();
        t_basic();
        t_stop(1'b0);
        t_stop(1'b1);
        t_ext();
        t_wrap_ovf();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule